// File: doc/BRIEF.md
# Port I/O Request Responder

This block services port I/O accesses that processor cores send as fixed-format request frames. A frame is eleven 32-bit words that arrive in index order on a valid/ready input. Words 0 and 1 hold a 64-bit data lane. Words 8, 9 and 10 carry the header: a byte-enable bitmap, a transaction tag, the sender and recipient ports, a 34-bit aligned address, a command code, a mesh route and a destination ID. The block keeps exactly one frame. Input ready stays low from the capture of the last word until the completion frame has been fully accepted downstream. That final handshake releases the buffer, so a burst of requests can never overwrite a frame that is still being handled.

Frames addressed to another recipient port are dropped silently. For an accepted frame, the byte-enable bitmap selects the accessed bytes within the 8-byte lane, and the block turns it into a port number and an access size. A write is reported on a one-cycle notify output that carries the port, the size and the value, which is aligned down to bit 0. A read is fetched through a request/grant interface. In both cases the block then sends an eleven-word completion frame. In that frame the sender and recipient ports swap places in the header, and a completion type is inserted.

Top module: `pio_responder`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid`, `wr_valid` and `rd_req` are 0. A request frame is taken as 11 words, indices 0 to 10, one per `in_valid && in_ready` cycle. Gaps in `in_valid` are allowed.
- R2: `in_ready` is 0 from the cycle after word 10 is accepted until the cycle after the last completion word is accepted, or until the drop decision is made. It is never high while `wr_valid`, `rd_req` or `out_valid` is high.
- R3: If the recipient port (word 10 bits 12:11) differs from parameter `HOST_PORT`, the frame produces no write notify, no read request and no completion frame. `in_ready` returns to 1 two cycles after word 10 is accepted.
- R4: With byte enable `be` = word 8 bits 7:0, the offset is the index of the lowest set bit of `be`. The port is the 34-bit address ({word 10 bits 1:0, word 9}) plus that offset. The size is the number of set bits in `be`.
- R5: If `be` is all zero, the offset and the size are both 0, and the request is still answered with a completion frame.
- R6: If the command (word 10 bits 10:2) equals `CMD_IO_WR`, `wr_valid` is high for exactly one cycle, one cycle after word 10 is accepted. It carries the port and the size, plus the value: bits 31:0 of the data lane ({word 1, word 0}) shifted right by 8 times the offset. The completion type is `CMP_MEM`, completion word 0 is request word 1, and completion word 1 is request word 0.
- R7: For any other command, `rd_req` stays high with the port and the size until `rd_gnt`. The completion type is `CMP_DATA`, completion word 0 is 0, and completion word 1 is the granted `rd_data`.
- R8: Completion word 8 is {sender port (request word 8 bits 23:16), 6'b0, recipient port, transaction tag (request word 8 bits 15:8), byte enable}.
- R9: Completion word 9 is the low 32 address bits. Completion word 10 is {7'b0, destination ID (request bits 24:22), route (request bits 21:14), 3'b0, completion type, address bits 33:32}. Completion words 2 to 7 are 0.
- R10: The completion frame is sent as 11 words in index order, with `out_last` high only on word 10. `out_word` and `out_last` hold steady while `out_valid` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request word valid |
| in_ready | output | 1 | Request buffer free |
| in_word | input | 32 | Request word |
| wr_valid | output | 1 | One-cycle write notify |
| wr_port | output | 34 | Write port number |
| wr_size | output | 4 | Write size in bytes |
| wr_value | output | 32 | Aligned write value |
| rd_req | output | 1 | Read fetch request |
| rd_gnt | input | 1 | Read fetch grant, data valid |
| rd_port | output | 34 | Read port number |
| rd_size | output | 4 | Read size in bytes |
| rd_data | input | 32 | Read value |
| out_valid | output | 1 | Completion word valid |
| out_ready | input | 1 | Completion word accepted |
| out_word | output | 32 | Completion word |
| out_last | output | 1 | Marks completion word 10 |

## Verification
The bench feeds byte enables whose lowest set bit sits at lanes 0, 2, 4 and 7, plus full, single-byte and all-zero maps. A decoder that counted the total number of clear bits, or that dropped the top lane, would report the wrong port. A design that skipped the all-zero case would leave the core with no answer. A foreign recipient port is sent between valid frames. A design that ignored the port check would emit a notify or a completion there, and one that forgot to reopen the buffer would hang the next frame. The completion frames are drained under a stall pattern and compared word by word. This catches un-swapped port fields, a misplaced completion type, and data halves that come out in the wrong order or change during a stall.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int WORD_W      = 32;
    localparam int FRAME_WORDS = 11;
    localparam int IDX_W       = 4;
    localparam int ADDR_W      = 34;
    localparam int LANE_BYTES  = 8;
    localparam int OFF_W       = $clog2(LANE_BYTES);
    localparam int SIZE_W      = OFF_W + 1;
    localparam int CMD_W       = 9;
    // Word positions inside a frame; the requesting core depends on them.
    localparam int W_DATA_LO   = 0;
    localparam int W_DATA_HI   = 1;
    localparam int W_TAGS      = 8;
    localparam int W_ADDR_LO   = 9;
    localparam int W_CTRL      = 10;

    typedef enum logic [1:0] {ST_CAP, ST_EVAL, ST_READ, ST_SEND} st_e;

    typedef struct packed {
        logic [7:0]            be;
        logic [7:0]            tag;
        logic [7:0]            sender;
        logic [ADDR_W-1:0]     addr;
        logic [CMD_W-1:0]      cmd;
        logic [1:0]            rcpt;
        logic [7:0]            route;
        logic [2:0]            dest;
        logic [2*WORD_W-1:0]   data0;
    } req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] port;
        logic [SIZE_W-1:0] size;
    } lane_t;

    function automatic logic [OFF_W-1:0] lowest_lane(input logic [LANE_BYTES-1:0] be);
        logic [OFF_W-1:0] r;
        r = '0;
        for (int i = LANE_BYTES - 1; i >= 0; i--)
            if (be[i]) r = OFF_W'(i);
        return r;
    endfunction

    function automatic logic [SIZE_W-1:0] ones_in(input logic [LANE_BYTES-1:0] be);
        logic [SIZE_W-1:0] n;
        n = '0;
        for (int i = 0; i < LANE_BYTES; i++)
            n = n + SIZE_W'(be[i]);
        return n;
    endfunction
endpackage

// File: rtl/pio_capture.sv
module pio_capture
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [WORD_W-1:0] word,
    output req_t              req,
    output logic              done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    logic [IDX_W-1:0] idx_q;

    assign done = accept && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            req   <= '0;
        end else if (accept) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
            if (idx_q == IDX_W'(W_DATA_LO)) req.data0[WORD_W-1:0] <= word;
            if (idx_q == IDX_W'(W_DATA_HI)) req.data0[2*WORD_W-1:WORD_W] <= word;
            if (idx_q == IDX_W'(W_TAGS)) begin
                req.be     <= word[7:0];
                req.tag    <= word[15:8];
                req.sender <= word[23:16];
            end
            if (idx_q == IDX_W'(W_ADDR_LO)) req.addr[31:0] <= word;
            if (idx_q == IDX_W'(W_CTRL)) begin
                req.addr[ADDR_W-1:32] <= word[1:0];
                req.cmd   <= word[10:2];
                req.rcpt  <= word[12:11];
                req.route <= word[21:14];
                req.dest  <= word[24:22];
            end
        end
    end
endmodule

// File: rtl/pio_lane_decode.sv
module pio_lane_decode
    import pio_pkg::*;
(
    input  req_t              req,
    output lane_t             lane,
    output logic [WORD_W-1:0] value
);
    logic [OFF_W-1:0]      off;
    logic [2*WORD_W-1:0]   shifted;

    always_comb begin
        off       = lowest_lane(req.be);
        lane.port = req.addr + ADDR_W'(off);
        lane.size = ones_in(req.be);
        shifted   = req.data0 >> {off, 3'b000};
        value     = shifted[WORD_W-1:0];
    end
endmodule

// File: rtl/pio_resp_pack.sv
module pio_resp_pack
    import pio_pkg::*;
(
    input  req_t                req,
    input  logic [CMD_W-1:0]    ctype,
    input  logic [2*WORD_W-1:0] data0,
    input  logic [IDX_W-1:0]    idx,
    output logic [WORD_W-1:0]   word
);
    logic [FRAME_WORDS-1:0][WORD_W-1:0] frame;

    always_comb begin
        for (int i = 0; i < FRAME_WORDS; i++) frame[i] = '0;
        // Data lane goes back high half first.
        frame[W_DATA_LO] = data0[2*WORD_W-1:WORD_W];
        frame[W_DATA_HI] = data0[WORD_W-1:0];
        frame[W_TAGS]    = {req.sender, 6'b0, req.rcpt, req.tag, req.be};
        frame[W_ADDR_LO] = req.addr[31:0];
        frame[W_CTRL]    = {7'b0, req.dest, req.route, 3'b0, ctype, req.addr[ADDR_W-1:32]};
        word = (idx < IDX_W'(FRAME_WORDS)) ? frame[idx] : '0;
    end
endmodule

// File: rtl/pio_responder.sv
module pio_responder
    import pio_pkg::*;
#(
    parameter logic [8:0] CMD_IO_WR = 9'h0A5,
    parameter logic [8:0] CMP_MEM   = 9'h1C3,
    parameter logic [8:0] CMP_DATA  = 9'h1C7,
    parameter logic [1:0] HOST_PORT = 2'd2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_word,
    output logic        wr_valid,
    output logic [33:0] wr_port,
    output logic [3:0]  wr_size,
    output logic [31:0] wr_value,
    output logic        rd_req,
    input  logic        rd_gnt,
    output logic [33:0] rd_port,
    output logic [3:0]  rd_size,
    input  logic [31:0] rd_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_word,
    output logic        out_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    st_e                 state_q;
    req_t                req;
    lane_t               lane;
    logic                cap_done;
    logic [WORD_W-1:0]   wr_val;
    logic [IDX_W-1:0]    oidx_q;
    logic [2*WORD_W-1:0] data0_q;
    logic [CMD_W-1:0]    ctype_q;
    logic                host_ok;
    logic                is_wr;

    assign in_ready = (state_q == ST_CAP);
    assign host_ok  = (req.rcpt == HOST_PORT);
    assign is_wr    = (req.cmd == CMD_IO_WR);

    pio_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .accept (in_valid && in_ready),
        .word   (in_word),
        .req    (req),
        .done   (cap_done)
    );

    pio_lane_decode u_dec (
        .req   (req),
        .lane  (lane),
        .value (wr_val)
    );

    pio_resp_pack u_pack (
        .req   (req),
        .ctype (ctype_q),
        .data0 (data0_q),
        .idx   (oidx_q),
        .word  (out_word)
    );

    assign wr_valid  = (state_q == ST_EVAL) && host_ok && is_wr;
    assign wr_port   = lane.port;
    assign wr_size   = lane.size;
    assign wr_value  = wr_val;
    assign rd_req    = (state_q == ST_READ);
    assign rd_port   = lane.port;
    assign rd_size   = lane.size;
    assign out_valid = (state_q == ST_SEND);
    assign out_last  = out_valid && (oidx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CAP;
            oidx_q  <= '0;
            data0_q <= '0;
            ctype_q <= '0;
        end else begin
            case (state_q)
                ST_CAP: if (cap_done) state_q <= ST_EVAL;
                ST_EVAL: begin
                    oidx_q <= '0;
                    if (!host_ok) begin
                        state_q <= ST_CAP;
                    end else if (is_wr) begin
                        data0_q <= req.data0;
                        ctype_q <= CMP_MEM;
                        state_q <= ST_SEND;
                    end else begin
                        ctype_q <= CMP_DATA;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: if (rd_gnt) begin
                    data0_q <= {{WORD_W{1'b0}}, rd_data};
                    state_q <= ST_SEND;
                end
                ST_SEND: if (out_ready) begin
                    if (oidx_q == LAST_IDX) begin
                        oidx_q  <= '0;
                        state_q <= ST_CAP;
                    end else begin
                        oidx_q <= oidx_q + 1'b1;
                    end
                end
                default: state_q <= ST_CAP;
            endcase
        end
    end
endmodule

// File: rtl/pio_responder_chk.sv
module pio_responder_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        wr_valid,
    input logic [3:0]  wr_size,
    input logic        rd_req,
    input logic        rd_gnt,
    input logic [33:0] rd_port,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_word,
    input logic        out_last
);
    // R2: the buffer stays closed while its frame is being handled
    p_buffer_closed_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid || wr_valid || rd_req) |-> !in_ready);

    // R6: the write notify is a single-cycle pulse
    p_notify_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R6, R7: a write notify and a read fetch never overlap
    p_wr_rd_apart_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && rd_req));

    // R7: the read request holds with a steady port until granted
    p_read_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_port)));

    // R4: the size never exceeds the lane width
    p_size_bound_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_size <= 4'd8));

    // R10: a stalled completion word does not change
    p_out_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));

    // R10: the last marker only appears on a valid word
    p_last_qualified_r10: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
endmodule

bind pio_responder pio_responder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .wr_valid  (wr_valid),
    .wr_size   (wr_size),
    .rd_req    (rd_req),
    .rd_gnt    (rd_gnt),
    .rd_port   (rd_port),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_last  (out_last)
);

// File: tb/pio_responder_bench.sv
module pio_responder_bench;
    localparam logic [8:0] CMD_WR   = 9'h0A5;
    localparam logic [8:0] CMD_RD   = 9'h0A4;
    localparam logic [8:0] CMP_MEM  = 9'h1C3;
    localparam logic [8:0] CMP_DATA = 9'h1C7;
    localparam logic [1:0] HOST     = 2'd2;
    localparam logic [1:0] FOREIGN  = 2'd1;

    typedef struct packed {
        logic [7:0]  be;
        logic        wr;
        logic [33:0] addr;
        logic [63:0] d0;
        logic [31:0] rdv;
        logic [7:0]  tag;
        logic [7:0]  snd;
        logic [7:0]  route;
        logic [2:0]  dst;
        logic [2:0]  eoff;
        logic [3:0]  esize;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h0F, 1'b1, 34'h0_0000_03F8, 64'h11223344_55667788, 32'h0,        8'h11, 8'h21, 8'h35, 3'd1, 3'd0, 4'd4},
        '{8'hF0, 1'b1, 34'h2_1234_5670, 64'hAABBCCDD_01020304, 32'h0,        8'h12, 8'h22, 8'h46, 3'd2, 3'd4, 4'd4},
        '{8'h04, 1'b0, 34'h0_0000_0060, 64'h0,                 32'hCAFE0042, 8'h13, 8'h23, 8'h57, 3'd3, 3'd2, 4'd1},
        '{8'h0C, 1'b1, 34'h1_0000_0020, 64'h00000000_BEEF0000, 32'h0,        8'h14, 8'h24, 8'h68, 3'd4, 3'd2, 4'd2},
        '{8'h80, 1'b0, 34'h3_FFFF_FFF8, 64'h0,                 32'h5A5A1234, 8'h15, 8'h25, 8'h79, 3'd5, 3'd7, 4'd1},
        '{8'hFF, 1'b0, 34'h0_0000_0400, 64'h0,                 32'h87654321, 8'hFE, 8'hC0, 8'hFF, 3'd7, 3'd0, 4'd8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        wr_valid;
    logic [33:0] wr_port;
    logic [3:0]  wr_size;
    logic [31:0] wr_value;
    logic        rd_req;
    logic        rd_gnt = 1'b0;
    logic [33:0] rd_port;
    logic [3:0]  rd_size;
    logic [31:0] rd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic        out_last;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    pio_responder #(
        .CMD_IO_WR (CMD_WR),
        .CMP_MEM   (CMP_MEM),
        .CMP_DATA  (CMP_DATA),
        .HOST_PORT (HOST)
    ) u_pio_responder (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_ready (in_ready), .in_word (in_word),
        .wr_valid (wr_valid), .wr_port (wr_port), .wr_size (wr_size), .wr_value (wr_value),
        .rd_req (rd_req), .rd_gnt (rd_gnt), .rd_port (rd_port), .rd_size (rd_size), .rd_data (rd_data),
        .out_valid (out_valid), .out_ready (out_ready), .out_word (out_word), .out_last (out_last)
    );

    task automatic check_eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input vec_t v, input logic [1:0] rcp, input bit gaps);
        logic [31:0] w [11];
        logic [31:0] resp [11];
        logic [10:0] lastf;
        logic [33:0] gport;
        logic [3:0]  gsize;
        logic [31:0] gval;
        logic [63:0] shifted;
        logic [8:0]  ctype;
        int got, nwr, nrd, cyc;
        bit seen;

        for (int i = 0; i < 11; i++) w[i] = 32'hA5A5_0000 | i;
        w[0]  = v.d0[31:0];
        w[1]  = v.d0[63:32];
        w[8]  = {8'h00, v.snd, v.tag, v.be};
        w[9]  = v.addr[31:0];
        w[10] = {7'b0, v.dst, v.route, 1'b0, rcp, (v.wr ? CMD_WR : CMD_RD), v.addr[33:32]};

        for (int i = 0; i < 11; i++) begin
            if (gaps && (i % 2 == 1)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_word  = w[i];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        check_eq("R2", "in_ready right after word 10", {63'b0, in_ready}, 64'd0);

        if (rcp != HOST) begin
            seen = wr_valid || rd_req || out_valid;
            @(negedge clk);
            check_eq("R3", "in_ready back after drop", {63'b0, in_ready}, 64'd1);
            for (int k = 0; k < 12; k++) begin
                seen = seen || wr_valid || rd_req || out_valid;
                @(negedge clk);
            end
            check_eq("R3", "activity for foreign recipient", {63'b0, seen}, 64'd0);
            return;
        end

        got = 0; nwr = 0; nrd = 0; cyc = 0; lastf = '0;
        gport = '0; gsize = '0; gval = '0;
        while (got < 11 && cyc < 80) begin
            rd_gnt    = 1'b0;
            out_ready = (cyc % 3) != 2;
            if (wr_valid) begin
                nwr++; gport = wr_port; gsize = wr_size; gval = wr_value;
            end
            if (rd_req) begin
                if (nrd == 0) begin gport = rd_port; gsize = rd_size; end
                nrd++;
                rd_gnt  = 1'b1;
                rd_data = v.rdv;
            end
            if (out_valid && out_ready) begin
                resp[got]  = out_word;
                lastf[got] = out_last;
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        rd_gnt = 1'b0;
        out_ready = 1'b0;

        check_eq("R10", "completion words received", 64'(got), 64'd11);
        check_eq("R4", "port = address + lowest lane", {30'b0, gport}, {30'b0, v.addr + 34'(v.eoff)});
        check_eq("R4", "size = set byte enables", 64'(gsize), 64'(v.esize));
        shifted = v.d0 >> (8 * v.eoff);
        if (v.wr) begin
            check_eq("R6", "write notify count", 64'(nwr), 64'd1);
            check_eq("R6", "read requests on write", 64'(nrd), 64'd0);
            check_eq("R6", "aligned write value", 64'(gval), 64'(shifted[31:0]));
            ctype = CMP_MEM;
            check_eq("R6", "completion word 0", 64'(resp[0]), 64'(v.d0[63:32]));
            check_eq("R6", "completion word 1", 64'(resp[1]), 64'(v.d0[31:0]));
        end else begin
            check_eq("R7", "read grants used", 64'(nrd), 64'd1);
            check_eq("R7", "write notifies on read", 64'(nwr), 64'd0);
            ctype = CMP_DATA;
            check_eq("R7", "completion word 0", 64'(resp[0]), 64'd0);
            check_eq("R7", "completion word 1", 64'(resp[1]), 64'(v.rdv));
        end
        check_eq("R8", "completion word 8", 64'(resp[8]), 64'({v.snd, 6'b0, HOST, v.tag, v.be}));
        check_eq("R9", "completion word 9", 64'(resp[9]), 64'(v.addr[31:0]));
        check_eq(v.wr ? "R6 R9" : "R7 R9", "completion word 10", 64'(resp[10]),
                 64'({7'b0, v.dst, v.route, 3'b0, ctype, v.addr[33:32]}));
        check_eq("R9", "completion words 2..7 OR", 64'(resp[2] | resp[3] | resp[4] | resp[5] | resp[6] | resp[7]), 64'd0);
        check_eq("R10", "last marker pattern", 64'(lastf), 64'h400);
        check_eq("R2", "in_ready after completion", {63'b0, in_ready}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        vec_t z;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "in_ready after reset", {63'b0, in_ready}, 64'd1);
        check_eq("R1", "out_valid after reset", {63'b0, out_valid}, 64'd0);
        check_eq("R1", "wr_valid after reset", {63'b0, wr_valid}, 64'd0);
        check_eq("R1", "rd_req after reset", {63'b0, rd_req}, 64'd0);

        for (int k = 0; k < NV; k++) run_frame(VECS[k], HOST, (k % 2) == 1);

        // R3: foreign recipient dropped, then a normal frame still works
        run_frame(VECS[0], FOREIGN, 1'b0);
        run_frame(VECS[2], HOST, 1'b0);

        // R5: all-zero byte enable, write and read, still answered
        z = '{8'h00, 1'b1, 34'h0_0000_0100, 64'h00000000_99887766, 32'h0, 8'h31, 8'h41, 8'h51, 3'd6, 3'd0, 4'd0};
        run_frame(z, HOST, 1'b0);
        z.wr = 1'b0; z.rdv = 32'h0000_00E5;
        run_frame(z, HOST, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule